// File: doc/BRIEF.md
# Endpoint Interrupt Flag Register Bank

This block keeps the interrupt status flags of every endpoint of a USB device controller. The endpoint engine reports events as single-cycle pulses: a stall, a failed transfer, a completed transfer, or a received setup packet. Alongside each pulse it gives the endpoint's direction (IN or OUT), whether it runs one bank or two, and which bank is currently active. The block works out from these whether a stall, fail or complete event belongs to the bank-0 flag or the bank-1 flag of that endpoint, and latches it there.

Software sees three byte-wide registers per endpoint: the flag register, an enable-clear register and an enable-set register. A flag is cleared by writing a one to its bit. Enables are changed only by writing ones through the set or clear register. One interrupt line per endpoint is raised whenever any flag of that endpoint is set while its enable is on.

Top module: `usbep_intflag_bank`

## Requirements
- R1: After a synchronous active-low reset, every flag, every enable and every interrupt output is 0.
- R2: For endpoint n the flag register is at byte address 0x107 + n*0x20, the enable-clear register at 0x108 + n*0x20 and the enable-set register at 0x109 + n*0x20. The flag bit positions are 0 TRCPT0, 1 TRCPT1, 2 TRFAIL0, 3 TRFAIL1, 4 RXSTP, 5 STALL0, 6 STALL1. Bit 7 of all three registers reads 0.
- R3: A stall event sets STALL1 (bit 6) for a single-bank IN endpoint or a double-bank endpoint whose current bank is 1, and sets STALL0 (bit 5) for a single-bank OUT endpoint or a double-bank endpoint whose current bank is 0.
- R4: A transfer-fail event sets TRFAIL1 (bit 3) or TRFAIL0 (bit 2), using the same bank choice as R3.
- R5: A transfer-complete event sets TRCPT1 (bit 1) or TRCPT0 (bit 0), using the same bank choice as R3.
- R6: A received-setup event sets RXSTP (bit 4) whatever the direction, bank mode or current bank.
- R7: Writing the flag register clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: If an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R9: Writing a one to a bit of the enable-set register sets that enable. Writing a one to a bit of the enable-clear register clears it. Zero bits have no effect. Both registers read back the current enables.
- R10: The interrupt output of an endpoint is the OR, over the seven flags, of flag AND enable, delayed by one register. It rises one cycle after the enabled flag first reads as set, and falls one cycle after the flag or its enable goes to 0.
- R11: Writes to bit 7, or to an address that maps to no register, change no flag and no enable.
- R12: An event or a write on one endpoint leaves the flags and enables of every other endpoint unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_is_in | input | NUM_EP | Endpoint direction, 1 = IN |
| ep_dual | input | NUM_EP | 1 = endpoint runs two banks |
| ep_cur_bank | input | NUM_EP | Currently active bank of a double-bank endpoint |
| ev_stall | input | NUM_EP | Stall event pulse |
| ev_fail | input | NUM_EP | Transfer-fail event pulse |
| ev_cpt | input | NUM_EP | Transfer-complete event pulse |
| ev_setup | input | NUM_EP | Received-setup event pulse |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | NUM_EP | Interrupt per endpoint |

## Verification
An event or write applied before a rising edge is visible in the flag or enable read-back right after that edge, so it can be read in the next cycle. The interrupt lags the flag and enable state by one more edge. Its rise and fall are therefore due two edges after the event, write or enable change that caused them, and the bench checks both the cycle before (still old value) and the cycle of the change. The driver applies stimulus on the falling edge and queues the expected values for that exact cycle. The monitor compares them a moment later in the same low phase, after the combinational read path and the registered outputs have settled.

// File: rtl/usbep_flag_pkg.sv
// Shared constants and types for the endpoint interrupt flag bank.
// Assumes a seven-bit flag vector per endpoint; bit 7 of each register is reserved.
package usbep_flag_pkg;
    localparam int FLAG_W      = 7;
    localparam int BIT_CPT0    = 0;
    localparam int BIT_CPT1    = 1;
    localparam int BIT_FAIL0   = 2;
    localparam int BIT_FAIL1   = 3;
    localparam int BIT_SETUP   = 4;
    localparam int BIT_STALL0  = 5;
    localparam int BIT_STALL1  = 6;

    typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/usbep_bank_steer.sv
// Turns one endpoint's event pulses into a vector of flag-set requests.
// Picks bank 1 for single-bank IN or double-bank with bank 1 active, else bank 0.
// Assumes event inputs are single-cycle pulses from the endpoint engine.
module usbep_bank_steer
    import usbep_flag_pkg::*;
(
    input  logic      is_in,
    input  logic      dual,
    input  logic      cur_bank,
    input  logic      ev_stall,
    input  logic      ev_fail,
    input  logic      ev_cpt,
    input  logic      ev_setup,
    output flag_vec_t set_o
);
    logic use_b1;

    // Select the active bank once for all banked events.
    always_comb use_b1 = dual ? cur_bank : is_in;

    // Route each event to its bank-0 or bank-1 flag bit.
    always_comb begin
        set_o             = '0;
        set_o[BIT_CPT0]   = ev_cpt   & ~use_b1;
        set_o[BIT_CPT1]   = ev_cpt   &  use_b1;
        set_o[BIT_FAIL0]  = ev_fail  & ~use_b1;
        set_o[BIT_FAIL1]  = ev_fail  &  use_b1;
        set_o[BIT_SETUP]  = ev_setup;
        set_o[BIT_STALL0] = ev_stall & ~use_b1;
        set_o[BIT_STALL1] = ev_stall &  use_b1;
    end
endmodule

// File: rtl/usbep_ep_regs.sv
// Flag, enable and interrupt state of one endpoint.
// Flags: write-one-to-clear, hardware set wins over a same-cycle clear.
// Enables: changed through separate set and clear write strobes.
// Interrupt: registered OR of flag AND enable.
// Assumes at most one of the three write strobes is active per cycle.
module usbep_ep_regs
    import usbep_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  flag_vec_t  set_i,
    input  logic       flag_wr_i,
    input  logic       en_set_wr_i,
    input  logic       en_clr_wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] flag_o,
    output logic [7:0] en_o,
    output logic       irq_o
);
    flag_vec_t flag_q;
    flag_vec_t en_q;
    flag_vec_t clr_mask;
    logic      irq_q;

    // Build the clear mask from a flag-register write.
    always_comb clr_mask = flag_wr_i ? wdata_i[FLAG_W-1:0] : '0;

    // Update flags: clear first, then apply hardware sets so sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | set_i;
    end

    // Update enables from the set and clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n)           en_q <= '0;
        else if (en_set_wr_i) en_q <= en_q | wdata_i[FLAG_W-1:0];
        else if (en_clr_wr_i) en_q <= en_q & ~wdata_i[FLAG_W-1:0];
    end

    // Register the masked interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_q & en_q);
    end

    assign flag_o = {1'b0, flag_q};
    assign en_o   = {1'b0, en_q};
    assign irq_o  = irq_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
    // R7
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_i |=> ((flag_q & $past(wdata_i[FLAG_W-1:0]) & ~$past(set_i)) == '0));
    // R7
    no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));
    // R9
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_wr_i |=> ((en_q & $past(wdata_i[FLAG_W-1:0])) == $past(wdata_i[FLAG_W-1:0])));
    // R9
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_wr_i |=> ((en_q & $past(wdata_i[FLAG_W-1:0])) == '0));
    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & en_q)) |=> irq_o);
    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_q & en_q)) |=> !irq_o);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_wr_i, en_set_wr_i, en_clr_wr_i}));
endmodule

// File: rtl/usbep_addr_dec.sv
// Decodes the byte address into per-endpoint write strobes and muxes read data.
// Each endpoint owns three consecutive bytes at a fixed stride.
// Assumes the register windows of different endpoints do not overlap.
module usbep_addr_dec #(
    parameter int NUM_EP    = 8,
    parameter int ADDR_W    = 12,
    parameter int FLAG_BASE = 'h107,
    parameter int EP_STRIDE = 'h20
) (
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        wr_i,
    input  logic [NUM_EP-1:0][7:0]      flag_rd_i,
    input  logic [NUM_EP-1:0][7:0]      en_rd_i,
    output logic [NUM_EP-1:0]           flag_wr_o,
    output logic [NUM_EP-1:0]           enclr_wr_o,
    output logic [NUM_EP-1:0]           enset_wr_o,
    output logic [7:0]                  rdata_o
);
    localparam int ENCLR_BASE = FLAG_BASE + 1;
    localparam int ENSET_BASE = FLAG_BASE + 2;

    logic [NUM_EP-1:0] hit_flag;
    logic [NUM_EP-1:0] hit_enclr;
    logic [NUM_EP-1:0] hit_enset;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(FLAG_BASE  + g * EP_STRIDE);
        localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(ENCLR_BASE + g * EP_STRIDE);
        localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(ENSET_BASE + g * EP_STRIDE);

        // Compare the address against this endpoint's three registers.
        always_comb begin
            hit_flag[g]  = (addr_i == A_FLAG);
            hit_enclr[g] = (addr_i == A_ENCLR);
            hit_enset[g] = (addr_i == A_ENSET);
        end
    end

    assign flag_wr_o  = hit_flag  & {NUM_EP{wr_i}};
    assign enclr_wr_o = hit_enclr & {NUM_EP{wr_i}};
    assign enset_wr_o = hit_enset & {NUM_EP{wr_i}};

    // Return the addressed register, zero for unmapped addresses.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (hit_flag[i])                  rdata_o = rdata_o | flag_rd_i[i];
            if (hit_enclr[i] || hit_enset[i]) rdata_o = rdata_o | en_rd_i[i];
        end
    end
endmodule

// File: rtl/usbep_intflag_bank.sv
// Top of the endpoint interrupt flag bank: one steering unit and one
// register slice per endpoint, sharing a single byte-wide register port.
// Assumes event pulses last one cycle and reads are combinational.
module usbep_intflag_bank
    import usbep_flag_pkg::*;
#(
    parameter int NUM_EP    = 8,
    parameter int ADDR_W    = 12,
    parameter int FLAG_BASE = 'h107,
    parameter int EP_STRIDE = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] ep_is_in,
    input  logic [NUM_EP-1:0] ep_dual,
    input  logic [NUM_EP-1:0] ep_cur_bank,
    input  logic [NUM_EP-1:0] ev_stall,
    input  logic [NUM_EP-1:0] ev_fail,
    input  logic [NUM_EP-1:0] ev_cpt,
    input  logic [NUM_EP-1:0] ev_setup,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_EP-1:0] irq
);
    logic [NUM_EP-1:0][7:0] flag_rd;
    logic [NUM_EP-1:0][7:0] en_rd;
    logic [NUM_EP-1:0]      flag_wr;
    logic [NUM_EP-1:0]      enclr_wr;
    logic [NUM_EP-1:0]      enset_wr;

    usbep_addr_dec #(
        .NUM_EP    (NUM_EP),
        .ADDR_W    (ADDR_W),
        .FLAG_BASE (FLAG_BASE),
        .EP_STRIDE (EP_STRIDE)
    ) u_dec (
        .addr_i     (reg_addr),
        .wr_i       (reg_wr),
        .flag_rd_i  (flag_rd),
        .en_rd_i    (en_rd),
        .flag_wr_o  (flag_wr),
        .enclr_wr_o (enclr_wr),
        .enset_wr_o (enset_wr),
        .rdata_o    (reg_rdata)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        flag_vec_t set_vec;

        usbep_bank_steer u_steer (
            .is_in    (ep_is_in[g]),
            .dual     (ep_dual[g]),
            .cur_bank (ep_cur_bank[g]),
            .ev_stall (ev_stall[g]),
            .ev_fail  (ev_fail[g]),
            .ev_cpt   (ev_cpt[g]),
            .ev_setup (ev_setup[g]),
            .set_o    (set_vec)
        );

        usbep_ep_regs u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (set_vec),
            .flag_wr_i   (flag_wr[g]),
            .en_set_wr_i (enset_wr[g]),
            .en_clr_wr_i (enclr_wr[g]),
            .wdata_i     (reg_wdata),
            .flag_o      (flag_rd[g]),
            .en_o        (en_rd[g]),
            .irq_o       (irq[g])
        );

        // R3
        stall_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_stall[g] && (ep_dual[g] ? !ep_cur_bank[g] : !ep_is_in[g]))
            |=> flag_rd[g][BIT_STALL0]);
        // R3
        stall_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_stall[g] && (ep_dual[g] ? ep_cur_bank[g] : ep_is_in[g]))
            |=> flag_rd[g][BIT_STALL1]);
        // R6
        setup_any_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_setup[g] |=> flag_rd[g][BIT_SETUP]);
        // R2
        rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !flag_rd[g][7] && !en_rd[g][7]);
    end
endmodule

// File: tb/usbep_intflag_bank_tb.sv
`timescale 1ns/1ps
module usbep_intflag_bank_tb;
    localparam int NUM_EP = 8;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_EP-1:0] ep_is_in = '0, ep_dual = '0, ep_cur_bank = '0;
    logic [NUM_EP-1:0] ev_stall = '0, ev_fail = '0, ev_cpt = '0, ev_setup = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic [NUM_EP-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    usbep_intflag_bank u_dut (
        .clk(clk), .rst_n(rst_n), .ep_is_in(ep_is_in), .ep_dual(ep_dual),
        .ep_cur_bank(ep_cur_bank), .ev_stall(ev_stall), .ev_fail(ev_fail),
        .ev_cpt(ev_cpt), .ev_setup(ev_setup), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [ADDR_W-1:0] fa(int n); return ADDR_W'('h107 + n * 'h20); endfunction
    function automatic logic [ADDR_W-1:0] ca(int n); return ADDR_W'('h108 + n * 'h20); endfunction
    function automatic logic [ADDR_W-1:0] sa(int n); return ADDR_W'('h109 + n * 'h20); endfunction

    // Monitor: compare queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? irq : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cfg(input int n, input bit in_dir, input bit dual, input bit bank);
        ep_is_in[n] = in_dir; ep_dual[n] = dual; ep_cur_bank[n] = bank;
    endtask

    // kind: 0 stall, 1 fail, 2 complete, 3 setup
    task automatic pulse(input int n, input int kind);
        @(negedge clk);
        case (kind)
            0: ev_stall[n] = 1'b1;
            1: ev_fail[n]  = 1'b1;
            2: ev_cpt[n]   = 1'b1;
            default: ev_setup[n] = 1'b1;
        endcase
        @(negedge clk);
        ev_stall = '0; ev_fail = '0; ev_cpt = '0; ev_setup = '0;
    endtask

    task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        sb.push_back('{is_irq: 1'b0, exp: e, tag: tag});
    endtask

    task automatic chk_irq(input bit wait_edge, input logic [7:0] e, input string tag);
        if (wait_edge) @(negedge clk);
        sb.push_back('{is_irq: 1'b1, exp: e, tag: tag});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(fa(0), 8'h00, "R1 flag ep0");
        chk_rd(fa(7), 8'h00, "R1 flag ep7");
        chk_rd(sa(3), 8'h00, "R1 enable ep3");
        chk_irq(0, 8'h00, "R1 irq");

        // R3 stall steering in all four configurations
        cfg(0, 0, 0, 0); pulse(0, 0); chk_rd(fa(0), 8'h20, "R3 single OUT -> STALL0");
        cfg(1, 1, 0, 0); pulse(1, 0); chk_rd(fa(1), 8'h40, "R3 single IN -> STALL1");
        cfg(2, 0, 1, 1); pulse(2, 0); chk_rd(fa(2), 8'h40, "R3 dual bank1 -> STALL1");
        cfg(3, 1, 1, 0); pulse(3, 0); chk_rd(fa(3), 8'h20, "R3 dual bank0 IN -> STALL0");

        // R4 fail steering
        pulse(1, 1); chk_rd(fa(1), 8'h48, "R4 single IN -> TRFAIL1");
        wr(fa(0), 8'h20); pulse(0, 1); chk_rd(fa(0), 8'h04, "R4 single OUT -> TRFAIL0");
        pulse(3, 1); chk_rd(fa(3), 8'h24, "R4 dual bank0 -> TRFAIL0");

        // R5 complete steering
        cfg(4, 0, 1, 1); pulse(4, 2); chk_rd(fa(4), 8'h02, "R5 dual bank1 -> TRCPT1");
        cfg(5, 0, 0, 0); pulse(5, 2); chk_rd(fa(5), 8'h01, "R5 single OUT -> TRCPT0");

        // R6 setup independent of bank
        cfg(6, 1, 1, 1); pulse(6, 3); chk_rd(fa(6), 8'h10, "R6 setup dual bank1");
        cfg(5, 1, 0, 0); pulse(5, 3); chk_rd(fa(5), 8'h11, "R6 setup single IN");

        // R12 untouched endpoint and neighbours
        chk_rd(fa(7), 8'h00, "R12 ep7 untouched");
        chk_rd(fa(2), 8'h40, "R12 ep2 unchanged");

        // R7 write-one-to-clear
        wr(fa(1), 8'h00); chk_rd(fa(1), 8'h48, "R7 zero write no effect");
        wr(fa(1), 8'h08); chk_rd(fa(1), 8'h40, "R7 clear TRFAIL1 only");
        wr(fa(1), 8'hFF); chk_rd(fa(1), 8'h00, "R7 clear all");

        // R8 set wins over same-cycle clear
        cfg(5, 0, 0, 0);
        @(negedge clk);
        reg_addr = fa(5); reg_wdata = 8'h11; reg_wr = 1'b1; ev_cpt[5] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_cpt = '0;
        chk_rd(fa(5), 8'h01, "R8 set beats clear");

        // R11 reserved bit and unmapped addresses
        wr(fa(6), 8'h80); chk_rd(fa(6), 8'h10, "R11 bit7 write ignored");
        wr(12'h100, 8'hFF); chk_rd(fa(0), 8'h04, "R11 unmapped flag write");
        chk_rd(sa(0), 8'h00, "R11 unmapped enable write");

        // R9 enable set/clear with read-back on both addresses
        wr(sa(0), 8'hFF); chk_rd(sa(0), 8'h7F, "R9 enset readback");
        chk_rd(ca(0), 8'h7F, "R9 enclr readback");
        wr(ca(0), 8'h0F); chk_rd(sa(0), 8'h70, "R9 enclr clears ones only");
        wr(sa(0), 8'h00); chk_rd(ca(0), 8'h70, "R9 zero set no effect");
        chk_rd(sa(1), 8'h00, "R12 ep1 enables unchanged");
        chk_irq(0, 8'h00, "R10 no enabled flag on ep0");

        // R10 interrupt latency on rise and fall
        wr(fa(4), 8'hFF);
        wr(sa(4), 8'h01);
        cfg(4, 0, 0, 0);
        pulse(4, 2);
        chk_irq(0, 8'h00, "R10 irq not yet after flag");
        chk_irq(1, 8'h10, "R10 irq rises");
        wr(fa(4), 8'h01);
        chk_irq(0, 8'h10, "R10 irq still high after clear");
        chk_irq(1, 8'h00, "R10 irq falls");
        pulse(4, 2);
        chk_irq(1, 8'h10, "R10 irq again");
        wr(ca(4), 8'h01);
        chk_irq(0, 8'h10, "R10 irq lag on enable clear");
        chk_irq(1, 8'h00, "R10 irq falls on enable clear");
        chk_rd(fa(4), 8'h01, "R10 flag kept when disabled");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule